// File: doc/BRIEF.md
# Hardwired Timing-Step Control Unit

This block sequences a small register-transfer datapath built around one shared internal bus. A three-bit step counter is decoded into one-hot timing pulses. The opcode bits currently held in the datapath's instruction register are decoded into one-hot instruction lines. A grid of AND/OR terms combines the two to produce the strobes for each cycle: a drive-onto-bus enable for MBR, PC, IR, R0 and R1, a load-from-bus strobe for MAR, MBR, PC, IR, R0 and R1, a PC increment, and memory read and write.

Every instruction starts with the same three fetch steps. The last execution step of each opcode clears the counter, so the next instruction begins at T0. A memory read that memory has not yet acknowledged holds the counter at its current step. While it waits, the loads and the increment of that step are held back, so they happen only once, in the cycle where the read completes.

Top module: `hw_step_ctrl`

## Requirements
- R1: While rst_n is low, step_onehot reads 8'h01 (bit k set means step Tk), and in every cycle exactly one bit of step_onehot is set.
- R2: For every opcode, T0 asserts pc_drv and mar_ld. T1 asserts mem_rd, mbr_ld and pc_inc. T2 asserts mbr_drv and ir_ld. No other strobe is active in these steps.
- R3: At T3, opcode 0 (no operation) asserts nothing. Opcode 1 asserts r1_drv and r0_ld (R0 gets R1). Opcode 2 asserts r0_drv and r1_ld (R1 gets R0). Opcode 5 asserts r0_drv and pc_ld (jump to R0).
- R4: Opcode 3 (load R0 from the address in R1) asserts r1_drv and mar_ld at T3, mem_rd and mbr_ld at T4, and mbr_drv and r0_ld at T5. Opcode 4 (store R0 to the address in R1) asserts r1_drv and mar_ld at T3, r0_drv and mbr_ld at T4, and mem_wr at T5. Opcode 6 (load R1 with the word after the instruction) asserts pc_drv and mar_ld at T3, mem_rd, mbr_ld and pc_inc at T4, and mbr_drv and r1_ld at T5.
- R5: The counter advances by one step per cycle. After the last step of an instruction (T3 for opcodes 0, 1, 2 and 5; T5 for opcodes 3, 4 and 6) the next cycle is T0.
- R6: Opcode 7 (halt) asserts no strobe at T3, and the step stays at T3 until reset.
- R7: While mem_rd is high and mem_ready is low, the step does not change and mbr_ld and pc_inc stay low. mem_rd stays asserted.
- R8: At most one of mbr_drv, pc_drv, ir_drv, r0_drv and r1_drv is high in any cycle.
- R9: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| opcode | input | 3 | Opcode field of the instruction register |
| mem_ready | input | 1 | Memory has completed the current read |
| step_onehot | output | 8 | Decoded timing pulses T0..T7 |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mbr_drv | output | 1 | MBR drives the bus |
| pc_drv | output | 1 | PC drives the bus |
| ir_drv | output | 1 | IR drives the bus |
| r0_drv | output | 1 | R0 drives the bus |
| r1_drv | output | 1 | R1 drives the bus |
| mar_ld | output | 1 | MAR loads from the bus |
| mbr_ld | output | 1 | MBR loads (from memory or the bus) |
| pc_ld | output | 1 | PC loads from the bus |
| ir_ld | output | 1 | IR loads from the bus |
| r0_ld | output | 1 | R0 loads from the bus |
| r1_ld | output | 1 | R1 loads from the bus |
| pc_inc | output | 1 | PC increments |

## Verification
The strobes are pure decode of the step counter, so a wrong counter value shows at the ports in the same cycle as a step_onehot mismatch and a wrong strobe set. A missed clear or a missed hold shows one cycle after the step where it should have acted. A missed stall shows as a doubled mbr_ld or pc_inc while mem_ready is low. The sweep runs every opcode under three memory-ready patterns and compares every cycle against a step model, so any such fault is caught within the instruction where it first occurs.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic mbr_drv;
    logic pc_drv;
    logic ir_drv;
    logic r0_drv;
    logic r1_drv;
    logic mar_ld;
    logic mbr_ld;
    logic pc_ld;
    logic ir_ld;
    logic r0_ld;
    logic r1_ld;
    logic pc_inc;
    logic cnt_clr;
    logic cnt_hold;
  } strobe_t;
endpackage

// File: rtl/hsc_rst_sync.sv
module hsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/hsc_step_counter.sv
module hsc_step_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         hold,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  // hold wins over clear; clear wins over increment
  assign cnt_en = !hold;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/hsc_onehot_dec.sv
module hsc_onehot_dec #(
  parameter int W = 3,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] sel,
  output logic [N-1:0] lines
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign lines[i] = (sel == W'(i));
  end
endmodule

// File: rtl/hsc_strobe_matrix.sv
module hsc_strobe_matrix
  import hsc_pkg::*;
#(
  parameter int NT = 8,
  parameter int NI = 8
) (
  input  logic [NT-1:0] t,
  input  logic [NI-1:0] ins,
  input  logic          mem_ready,
  output strobe_t       strb
);
  strobe_t raw;
  logic    stall;

  always_comb begin
    raw = '0;
    // fetch, common to every opcode
    raw.pc_drv  = t[0] | (t[3] & ins[6]);
    raw.mar_ld  = t[0] | (t[3] & (ins[3] | ins[4] | ins[6]));
    raw.mem_rd  = t[1] | (t[4] & (ins[3] | ins[6]));
    raw.mbr_ld  = t[1] | (t[4] & (ins[3] | ins[4] | ins[6]));
    raw.pc_inc  = t[1] | (t[4] & ins[6]);
    raw.mbr_drv = t[2] | (t[5] & (ins[3] | ins[6]));
    raw.ir_ld   = t[2];
    // execution
    raw.r1_drv  = t[3] & (ins[1] | ins[3] | ins[4]);
    raw.r0_drv  = (t[3] & (ins[2] | ins[5])) | (t[4] & ins[4]);
    raw.r0_ld   = (t[3] & ins[1]) | (t[5] & ins[3]);
    raw.r1_ld   = (t[3] & ins[2]) | (t[5] & ins[6]);
    raw.pc_ld   = t[3] & ins[5];
    raw.mem_wr  = t[5] & ins[4];
    raw.ir_drv  = 1'b0;
    raw.cnt_clr = (t[3] & (ins[0] | ins[1] | ins[2] | ins[5]))
                | (t[5] & (ins[3] | ins[4] | ins[6]))
                | t[6] | t[7];
    raw.cnt_hold = t[3] & ins[7];
  end

  assign stall = raw.mem_rd & ~mem_ready;

  always_comb begin
    strb          = raw;
    strb.mbr_ld   = raw.mbr_ld & ~stall;
    strb.pc_inc   = raw.pc_inc & ~stall;
    strb.cnt_hold = raw.cnt_hold | stall;
  end
endmodule

// File: rtl/hw_step_ctrl.sv
module hw_step_ctrl
  import hsc_pkg::*;
#(
  parameter int STEP_W = 3,
  parameter int OP_W   = 3,
  localparam int NT    = 1 << STEP_W,
  localparam int NI    = 1 << OP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  input  logic            mem_ready,
  output logic [NT-1:0]   step_onehot,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            mbr_drv,
  output logic            pc_drv,
  output logic            ir_drv,
  output logic            r0_drv,
  output logic            r1_drv,
  output logic            mar_ld,
  output logic            mbr_ld,
  output logic            pc_ld,
  output logic            ir_ld,
  output logic            r0_ld,
  output logic            r1_ld,
  output logic            pc_inc
);
  logic              rst_sync_n;
  logic [STEP_W-1:0] step;
  logic [NI-1:0]     ins_lines;
  strobe_t           strb;

  hsc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  hsc_step_counter #(.W(STEP_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clr(strb.cnt_clr),
    .hold(strb.cnt_hold), .cnt(step));

  hsc_onehot_dec #(.W(STEP_W)) u_tdec (.sel(step), .lines(step_onehot));
  hsc_onehot_dec #(.W(OP_W))   u_idec (.sel(opcode), .lines(ins_lines));

  hsc_strobe_matrix #(.NT(NT), .NI(NI)) u_mat (
    .t(step_onehot), .ins(ins_lines), .mem_ready(mem_ready), .strb(strb));

  assign mem_rd  = strb.mem_rd;
  assign mem_wr  = strb.mem_wr;
  assign mbr_drv = strb.mbr_drv;
  assign pc_drv  = strb.pc_drv;
  assign ir_drv  = strb.ir_drv;
  assign r0_drv  = strb.r0_drv;
  assign r1_drv  = strb.r1_drv;
  assign mar_ld  = strb.mar_ld;
  assign mbr_ld  = strb.mbr_ld;
  assign pc_ld   = strb.pc_ld;
  assign ir_ld   = strb.ir_ld;
  assign r0_ld   = strb.r0_ld;
  assign r1_ld   = strb.r1_ld;
  assign pc_inc  = strb.pc_inc;
endmodule

// File: rtl/hsc_checker.sv
module hsc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] opcode,
  input logic       mem_ready,
  input logic [7:0] step_onehot,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       mbr_drv,
  input logic       pc_drv,
  input logic       ir_drv,
  input logic       r0_drv,
  input logic       r1_drv,
  input logic       ir_ld,
  input logic       mbr_ld,
  input logic       pc_inc
);
  logic [4:0] drives;
  assign drives = {mbr_drv, pc_drv, ir_drv, r0_drv, r1_drv};

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_onehot) == 1); // R1
  AST_FETCH_IR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    step_onehot[2] |-> (ir_ld && mbr_drv)); // R2
  AST_LAST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    step_onehot[5] |=> step_onehot[0]); // R5
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_onehot[3] && opcode == 3'd7) |=> step_onehot[3]); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> $stable(step_onehot)); // R7
  AST_STALL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |-> (!mbr_ld && !pc_inc)); // R7
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(drives) <= 1); // R8
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R9
endmodule

bind hw_step_ctrl hsc_checker u_hsc_checker (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .mem_ready(mem_ready),
  .step_onehot(step_onehot), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mbr_drv(mbr_drv), .pc_drv(pc_drv), .ir_drv(ir_drv), .r0_drv(r0_drv),
  .r1_drv(r1_drv), .ir_ld(ir_ld), .mbr_ld(mbr_ld), .pc_inc(pc_inc));

// File: tb/hw_step_ctrl_bench.sv
`timescale 1ns/1ps
module hw_step_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] opcode;
  logic       mem_ready;
  logic [7:0] step_onehot;
  logic mem_rd, mem_wr, mbr_drv, pc_drv, ir_drv, r0_drv, r1_drv;
  logic mar_ld, mbr_ld, pc_ld, ir_ld, r0_ld, r1_ld, pc_inc;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hw_step_ctrl u_hw_step_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .mem_ready(mem_ready),
    .step_onehot(step_onehot), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mbr_drv(mbr_drv), .pc_drv(pc_drv), .ir_drv(ir_drv), .r0_drv(r0_drv),
    .r1_drv(r1_drv), .mar_ld(mar_ld), .mbr_ld(mbr_ld), .pc_ld(pc_ld),
    .ir_ld(ir_ld), .r0_ld(r0_ld), .r1_ld(r1_ld), .pc_inc(pc_inc));

  // strobe vector bit positions (MSB first):
  // mem_rd mem_wr mbr_drv pc_drv ir_drv r0_drv r1_drv mar_ld mbr_ld pc_ld ir_ld r0_ld r1_ld pc_inc
  localparam int RD = 13, WR = 12, MBRD = 11, PCD = 10, IRD = 9, R0D = 8, R1D = 7;
  localparam int MARL = 6, MBRL = 5, PCL = 4, IRL = 3, R0L = 2, R1L = 1, PCI = 0;

  function automatic logic [13:0] raw_exp(input int st, input int op);
    logic [13:0] v = '0;
    case (st)
      0: begin v[PCD] = 1; v[MARL] = 1; end
      1: begin v[RD] = 1; v[MBRL] = 1; v[PCI] = 1; end
      2: begin v[MBRD] = 1; v[IRL] = 1; end
      3: case (op)
           1: begin v[R1D] = 1; v[R0L] = 1; end
           2: begin v[R0D] = 1; v[R1L] = 1; end
           3, 4: begin v[R1D] = 1; v[MARL] = 1; end
           5: begin v[R0D] = 1; v[PCL] = 1; end
           6: begin v[PCD] = 1; v[MARL] = 1; end
           default: ;
         endcase
      4: case (op)
           3: begin v[RD] = 1; v[MBRL] = 1; end
           4: begin v[R0D] = 1; v[MBRL] = 1; end
           6: begin v[RD] = 1; v[MBRL] = 1; v[PCI] = 1; end
           default: ;
         endcase
      5: case (op)
           3: begin v[MBRD] = 1; v[R0L] = 1; end
           4: v[WR] = 1;
           6: begin v[MBRD] = 1; v[R1L] = 1; end
           default: ;
         endcase
      default: ;
    endcase
    return v;
  endfunction

  function automatic string tag_of(input int st, input int op);
    if (st < 3) return "R2";
    if (op == 7) return "R6";
    if (op == 3 || op == 4 || op == 6) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  function automatic logic ready_of(input int pat, input int cyc);
    case (pat)
      0: return 1'b1;
      1: return (cyc % 3) == 2;
      default: return cyc[0];
    endcase
  endfunction

  task automatic run(input int op, input int pat);
    int st;
    logic [13:0] e;
    logic [13:0] act;
    logic stall;
    rst_n = 1'b0;
    opcode = 3'(op);
    mem_ready = 1'b1;
    @(negedge clk);
    #1;
    check("R1", 32'(step_onehot), 32'h01);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    st = 0;
    for (int cyc = 0; cyc < 16; cyc++) begin
      @(negedge clk);
      mem_ready = ready_of(pat, cyc);
      #1;
      e = raw_exp(st, op);
      stall = e[RD] && !mem_ready;
      if (stall) begin e[MBRL] = 1'b0; e[PCI] = 1'b0; end
      act = {mem_rd, mem_wr, mbr_drv, pc_drv, ir_drv, r0_drv, r1_drv,
             mar_ld, mbr_ld, pc_ld, ir_ld, r0_ld, r1_ld, pc_inc};
      check(cyc == 0 ? "R1" : "R5", 32'(step_onehot), 32'h1 << st);
      check(tag_of(st, op), 32'(act), 32'(e));
      check("R8", 32'($countones({mbr_drv, pc_drv, ir_drv, r0_drv, r1_drv}) <= 1), 32'd1);
      check("R9", 32'(mem_rd & mem_wr), 32'd0);
      if (stall) check("R7", 32'({mbr_ld, pc_inc}), 32'd0);
      // advance the model to the next step
      if (stall) st = st;
      else if (st == 3 && op == 7) st = 3;
      else if (st == 3 && (op == 0 || op == 1 || op == 2 || op == 5)) st = 0;
      else if (st == 5) st = 0;
      else st = st + 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    opcode = '0;
    mem_ready = 1'b1;
    repeat (2) @(posedge clk);
    for (int pat = 0; pat < 3; pat++)
      for (int op = 0; op < 8; op++)
        run(op, pat);
    summary();
  end
endmodule